// File: doc/BRIEF.md
# Dual-Bus CAN Repeater Logic Core

This block is the digital core between one local CAN controller, an expansion port for cascading several such cores, and two CAN bus segments. It takes the local and expansion transmit lines, two active-low bus enables, the two bus comparator outputs and a thermal shutdown flag. It produces one transmit-dominant request per bus and two receive lines: one for the local controller and one for the expansion port. Every digital line uses low for dominant and high for recessive.

A dominant level from either transmit port is sent to both enabled buses. A dominant level seen on one enabled bus is repeated onto the other and reported on both receive lines. While the core drives a bus dominant, and for a hold-off window after it stops, reception on that bus is masked. Without this mask the two segments would latch each other dominant. Each of the four input paths has its own stuck-dominant time-out, so a frozen input cannot block both segments.

All asynchronous inputs first pass through a synchronizer, and all outputs are registered. The hold-off window and the time-out are parameters counted in system-clock cycles.

Top module: `can_dual_repeater`

## Requirements
- R1: While `rst_n` is low, and on the first clock edges after it rises, all four outputs are high (recessive), and all timers and hold-off counters are cleared.
- R2: An input change reaches the outputs on the third rising clock edge after it is applied (two synchronizer stages plus one output register).
- R3: A low on `ltx_n` pulls `lrx_n` and `xrx_n` low whatever the enables are, and pulls `drv_a_n`/`drv_b_n` low for each bus whose enable is low.
- R4: A low on `xtx_n` pulls `lrx_n` low and the drive output of each enabled bus low. It does not change `xrx_n`.
- R5: While a bus enable is high, that bus's drive output stays high and its comparator input has no effect on any output.
- R6: A low comparator output on an enabled bus (not masked) pulls the drive output of the other enabled bus low and pulls both `lrx_n` and `xrx_n` low.
- R7: Comparator input of a bus is ignored while that bus's drive output is low and for HOLD_CYC cycles after it returns high.
- R8: Each path (local transmit, expansion transmit, bus A receive, bus B receive) passes a continuous dominant for exactly TMO_CYC cycles. After that the path reads recessive.
- R9: A timed-out path is released once its input reads recessive, and a new dominant starts a fresh count.
- R10: While `therm_i` is high, both drive outputs are high. Receive routing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ltx_n | input | 1 | Local controller transmit, low = dominant |
| xtx_n | input | 1 | Expansion transmit, low = dominant |
| en_a_n | input | 1 | Bus A enable, active low |
| en_b_n | input | 1 | Bus B enable, active low |
| cmp_a_n | input | 1 | Bus A comparator output, low = dominant seen |
| cmp_b_n | input | 1 | Bus B comparator output, low = dominant seen |
| therm_i | input | 1 | Thermal shutdown flag, high = transmitters off |
| drv_a_n | output | 1 | Bus A transmit request, low = drive dominant |
| drv_b_n | output | 1 | Bus B transmit request, low = drive dominant |
| lrx_n | output | 1 | Local controller receive line, low = dominant |
| xrx_n | output | 1 | Expansion receive line, low = dominant |

## Verification
The assertions assume that the synchronized inputs are steady between clock edges. They also assume that a bus's comparator echo of its own drive arrives within the masking window. The stimulus changes inputs only at falling clock edges. In the feedback scenarios, the echo of a drive is always released within HOLD_CYC cycles, unless the test deliberately keeps the comparator low beyond that window to expose the mask end. The random phases are mostly short, with occasional long holds, so that the time-out is reached on every path without stalling the run.

// File: rtl/can_rep_pkg.sv
package can_rep_pkg;
    // synchronized input vector bit positions
    localparam int unsigned IN_LTX   = 0;
    localparam int unsigned IN_XTX   = 1;
    localparam int unsigned IN_ENA   = 2;
    localparam int unsigned IN_ENB   = 3;
    localparam int unsigned IN_CMPA  = 4;
    localparam int unsigned IN_CMPB  = 5;
    localparam int unsigned IN_THERM = 6;
    localparam int unsigned IN_W     = 7;

    // timed path indices
    localparam int unsigned P_LTX = 0;
    localparam int unsigned P_XTX = 1;
    localparam int unsigned P_RXA = 2;
    localparam int unsigned P_RXB = 3;
    localparam int unsigned NPATH = 4;

    // registered output state, 1 = dominant
    typedef struct packed {
        logic drv_a;
        logic drv_b;
        logic lrx;
        logic xrx;
    } out_st_t;
endpackage

// File: rtl/can_rep_sync.sv
module can_rep_sync #(
    parameter int unsigned W      = 7,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/can_rep_dom_timer.sv
module can_rep_dom_timer #(
    parameter int unsigned TMO_CYC = 5_000_000,
    localparam int unsigned CW = $clog2(TMO_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dom_i,
    output logic dom_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          expd;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!dom_i) begin
            st_d = '0;
        end else if (!st_q.expd) begin
            if (st_q.cnt == CW'(TMO_CYC - 1)) st_d.expd = 1'b1;
            else                              st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dom_o = dom_i & ~st_q.expd;

    // R9
    release_on_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dom_i |=> !st_q.expd);
    // R8
    expire_needs_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.expd) |-> $past(dom_i));
    // R8
    expire_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.expd && dom_i |=> !dom_o);
endmodule

// File: rtl/can_rep_fb_mask.sv
module can_rep_fb_mask #(
    parameter int unsigned HOLD_CYC = 60,
    localparam int unsigned HW = $clog2(HOLD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_dom_i,
    output logic mask_o
);
    logic [HW-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (drv_dom_i)          hold_d = HW'(HOLD_CYC);
        else if (hold_q != '0)  hold_d = hold_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign mask_o = drv_dom_i | (hold_q != '0);

    // R7
    mask_after_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_dom_i |=> mask_o);
    // R7
    mask_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_dom_i) |-> mask_o);
endmodule

// File: rtl/can_dual_repeater.sv
module can_dual_repeater
    import can_rep_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HOLD_CYC    = 60,
    parameter int unsigned TMO_CYC     = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ltx_n,
    input  logic xtx_n,
    input  logic en_a_n,
    input  logic en_b_n,
    input  logic cmp_a_n,
    input  logic cmp_b_n,
    input  logic therm_i,
    output logic drv_a_n,
    output logic drv_b_n,
    output logic lrx_n,
    output logic xrx_n
);
    localparam logic [IN_W-1:0] SYNC_RST = {1'b0, {(IN_W-1){1'b1}}};

    logic [IN_W-1:0]  raw_in, syn;
    logic             en_a, en_b, therm_s, mask_a, mask_b;
    logic [NPATH-1:0] path_in, path_out;
    logic             tx_any;
    out_st_t          st_d, st_q;

    assign raw_in = {therm_i, cmp_b_n, cmp_a_n, en_b_n, en_a_n, xtx_n, ltx_n};

    can_rep_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn)
    );

    assign en_a    = ~syn[IN_ENA];
    assign en_b    = ~syn[IN_ENB];
    assign therm_s =  syn[IN_THERM];

    can_rep_fb_mask #(.HOLD_CYC(HOLD_CYC)) u_mask_a (
        .clk(clk), .rst_n(rst_n), .drv_dom_i(st_q.drv_a), .mask_o(mask_a)
    );
    can_rep_fb_mask #(.HOLD_CYC(HOLD_CYC)) u_mask_b (
        .clk(clk), .rst_n(rst_n), .drv_dom_i(st_q.drv_b), .mask_o(mask_b)
    );

    assign path_in[P_LTX] = ~syn[IN_LTX];
    assign path_in[P_XTX] = ~syn[IN_XTX];
    assign path_in[P_RXA] = en_a & ~syn[IN_CMPA] & ~mask_a;
    assign path_in[P_RXB] = en_b & ~syn[IN_CMPB] & ~mask_b;

    for (genvar p = 0; p < NPATH; p++) begin : g_tmr
        can_rep_dom_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
            .clk(clk), .rst_n(rst_n), .dom_i(path_in[p]), .dom_o(path_out[p])
        );
    end

    assign tx_any = path_out[P_LTX] | path_out[P_XTX];

    always_comb begin
        st_d       = st_q;
        st_d.drv_a = ~therm_s & en_a & (tx_any | path_out[P_RXB]);
        st_d.drv_b = ~therm_s & en_b & (tx_any | path_out[P_RXA]);
        st_d.lrx   = tx_any | path_out[P_RXA] | path_out[P_RXB];
        st_d.xrx   = path_out[P_LTX] | path_out[P_RXA] | path_out[P_RXB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drv_a_n = ~st_q.drv_a;
    assign drv_b_n = ~st_q.drv_b;
    assign lrx_n   = ~st_q.lrx;
    assign xrx_n   = ~st_q.xrx;

    // R10
    therm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        therm_s |=> drv_a_n && drv_b_n);
    // R5
    dis_a_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_a |=> drv_a_n);
    // R5
    dis_b_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_b |=> drv_b_n);
    // R3
    local_tx_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        path_out[P_LTX] && en_a && !therm_s |=> !drv_a_n && !lrx_n && !xrx_n);
    // R4
    ext_tx_no_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        path_out[P_XTX] && !path_out[P_LTX] && !path_out[P_RXA] && !path_out[P_RXB]
        |=> xrx_n && !lrx_n);
    // R6
    bus_a_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        path_out[P_RXA] && en_b && !therm_s |=> !drv_b_n && !lrx_n && !xrx_n);
endmodule

// File: tb/sim_can_dual_repeater.sv
module sim_can_dual_repeater;
    localparam int TMO  = 40;
    localparam int HOLD = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ltx_n = 1'b1, xtx_n = 1'b1, en_a_n = 1'b0, en_b_n = 1'b0;
    logic cmp_a_n = 1'b1, cmp_b_n = 1'b1, therm_i = 1'b0;
    logic drv_a_n, drv_b_n, lrx_n, xrx_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    can_dual_repeater #(.SYNC_STAGES(2), .HOLD_CYC(HOLD), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .ltx_n(ltx_n), .xtx_n(xtx_n),
        .en_a_n(en_a_n), .en_b_n(en_b_n), .cmp_a_n(cmp_a_n), .cmp_b_n(cmp_b_n),
        .therm_i(therm_i), .drv_a_n(drv_a_n), .drv_b_n(drv_b_n),
        .lrx_n(lrx_n), .xrx_n(xrx_n)
    );

    // ---------------- reference model from the requirements ----------------
    bit [6:0] m_s1, m_s2;           // order: therm,cmpb,cmpa,enb,ena,xtx,ltx
    int       m_cnt [4];
    bit       m_exp [4];
    int       m_hold_a, m_hold_b;
    bit [3:0] m_out;                // {xrx,lrx,drvb,drva}, 1 = dominant

    function automatic bit [3:0] route(bit [3:0] t, bit ea, bit eb, bit th);
        bit tx;
        tx = t[0] | t[1];
        return {t[0] | t[2] | t[3], tx | t[2] | t[3],
                ~th & eb & (tx | t[2]), ~th & ea & (tx | t[3])};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 7'b0111111; m_s2 = 7'b0111111;
            for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_exp[i] = 1'b0; end
            m_hold_a = 0; m_hold_b = 0; m_out = '0;
        end else begin
            bit [3:0] raw, t, nout;
            bit ea, eb, mska, mskb;
            ea = ~m_s2[2]; eb = ~m_s2[3];
            mska = m_out[0] | (m_hold_a != 0);
            mskb = m_out[1] | (m_hold_b != 0);
            raw = {eb & ~m_s2[5] & ~mskb, ea & ~m_s2[4] & ~mska, ~m_s2[1], ~m_s2[0]};
            for (int i = 0; i < 4; i++) t[i] = raw[i] & ~m_exp[i];
            nout = route(t, ea, eb, m_s2[6]);
            for (int i = 0; i < 4; i++) begin
                if (!raw[i]) begin m_cnt[i] = 0; m_exp[i] = 1'b0; end
                else if (!m_exp[i]) begin
                    if (m_cnt[i] == TMO - 1) m_exp[i] = 1'b1;
                    else m_cnt[i] = m_cnt[i] + 1;
                end
            end
            if (m_out[0]) m_hold_a = HOLD; else if (m_hold_a != 0) m_hold_a = m_hold_a - 1;
            if (m_out[1]) m_hold_b = HOLD; else if (m_hold_b != 0) m_hold_b = m_hold_b - 1;
            m_out = nout;
            m_s2 = m_s1;
            m_s1 = {therm_i, cmp_b_n, cmp_a_n, en_b_n, en_a_n, xtx_n, ltx_n};
        end
    end

    // ---------------- helpers ----------------
    function automatic bit [3:0] act();
        return {xrx_n, lrx_n, drv_b_n, drv_a_n};
    endfunction

    task automatic chk(string tag, bit [3:0] exp_n);
        checks++;
        if (act() !== exp_n) begin
            errors++;
            $display("FAIL %s: {xrx,lrx,drvb,drva}_n actual=%b expected=%b at %0t",
                     tag, act(), exp_n, $time);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle();
        ltx_n = 1; xtx_n = 1; en_a_n = 0; en_b_n = 0;
        cmp_a_n = 1; cmp_b_n = 1; therm_i = 0;
        step(HOLD + 12);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        step(1);
        chk("R1 in reset", 4'b1111);
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 after reset", 4'b1111);
        step(4);

        // R2 / R3: latency and local transmit fan-out
        ltx_n = 0;
        step(2); chk("R2 before third edge", 4'b1111);
        step(1); chk("R3 local tx both buses", 4'b0000);
        idle();

        // R3 with both enables high: receive lines still low
        en_a_n = 1; en_b_n = 1; step(HOLD + 6);
        ltx_n = 0; step(4); chk("R3 local tx disabled buses", 4'b0011);
        idle();

        // R4: expansion transmit, xrx untouched
        xtx_n = 0; step(4); chk("R4 expansion tx", 4'b1000);
        idle();

        // R5: disabled bus ignores comparator and stays recessive
        en_a_n = 1; step(HOLD + 6);
        cmp_a_n = 0; step(6); chk("R5 disabled comparator ignored", 4'b1111);
        ltx_n = 0; step(4); chk("R5 disabled bus not driven", 4'b0001);
        idle();

        // R6: bus A dominant repeated onto bus B
        cmp_a_n = 0; step(4); chk("R6 bus A repeat", 4'b0001);
        idle();
        cmp_b_n = 0; step(4); chk("R6 bus B repeat", 4'b0010);
        idle();

        // R7: echo on the driven bus is masked during hold-off
        ltx_n = 0; cmp_a_n = 0; step(8);
        chk("R7 driving with echo", 4'b0000);
        ltx_n = 1; step(3);
        step(1); chk("R7 masked after release", 4'b1111);
        step(4); chk("R7 masked near hold end", 4'b1111);
        step(4); chk("R7 mask ended, echo repeats", 4'b0001);
        idle();

        // R8: time-out exact window on the local path
        ltx_n = 0;
        step(2 + TMO); chk("R8 last passed cycle", 4'b0000);
        step(1);       chk("R8 timed out", 4'b1111);
        step(10);      chk("R8 stays recessive", 4'b1111);
        // R9: release and restart
        ltx_n = 1; step(5);
        ltx_n = 0; step(3); chk("R9 restart after release", 4'b0000);
        idle();

        // R8 on a receive path
        cmp_b_n = 0;
        step(2 + TMO); chk("R8 rx path last", 4'b0010);
        step(1);       chk("R8 rx path timed out", 4'b1111);
        idle();

        // R10: thermal shutdown gates only drives
        therm_i = 1; ltx_n = 0; step(4); chk("R10 thermal local tx", 4'b0011);
        ltx_n = 1; cmp_a_n = 0; step(4); chk("R10 thermal bus rx", 4'b0011);
        idle();

        // random phases checked against the model every cycle
        for (int ph = 0; ph < 400; ph++) begin
            int len;
            ltx_n   = ($urandom_range(0, 99) >= 20);
            xtx_n   = ($urandom_range(0, 99) >= 15);
            en_a_n  = ($urandom_range(0, 99) < 20);
            en_b_n  = ($urandom_range(0, 99) < 20);
            cmp_a_n = ($urandom_range(0, 99) >= 20);
            cmp_b_n = ($urandom_range(0, 99) >= 20);
            therm_i = ($urandom_range(0, 99) < 8);
            len = ($urandom_range(0, 9) == 0) ? $urandom_range(TMO, TMO + 20)
                                              : $urandom_range(1, 12);
            for (int c = 0; c < len; c++) begin
                step(1);
                chk("R2 random vs model", ~m_out);
            end
        end

        finish_run();
    end
endmodule